// File: doc/BRIEF.md
# Segmented DAC Unary/Binary Drive Coder

This block turns an unsigned N-bit sample word into the drive pattern for a segmented resistor DAC. The M most significant bits of the word are expanded into a unary (thermometer) code of 2^M−1 lines, one line for each equal-weight segment resistor. The remaining N−M low bits pass through unchanged to drive the binary-weighted section. M is even, from 2 to 8.

The unary expansion is built as a chain of levels, and each level handles one bit pair. The lowest pair feeds a 2-bit fill unit. Every higher pair drives an active-low 2-to-4 decoder. Each output of that decoder chooses one of four groups. Groups below the chosen one are fully on, groups above it are off, and the chosen group takes the finer pattern from the level beneath. Three group-boundary lines separate the four groups. The unary lines and the binary bits are loaded together into one output register on the clock edge where the sample strobe is high. They all change on the same edge, and no settling of the decode is ever visible at the outputs.

Top module: `seg_dac_coder`

## Requirements
- R1: `unary_q` has 2^M−1 lines. After a load, bit k−1 (k = 1 … 2^M−1) is 1 exactly when the loaded segmented value `word_in[N-1:N-M]` is at least k. The lines therefore always form a contiguous run of ones starting at bit 0.
- R2: After a load, the number of ones in `unary_q` equals the loaded segmented value. A segmented value of 0 gives all zeros, and the maximum value gives all ones.
- R3: After a load, `binary_q` equals the loaded `word_in[N-M-1:0]`.
- R4: Outputs change only on a rising clock edge where `sample_stb` is 1. While the strobe is 0, changes on `word_in` have no effect on `unary_q` or `binary_q`.
- R5: While `rst_n` is 0, both `unary_q` and `binary_q` are all zeros. The clear is asynchronous.
- R6: The unary and binary fields of one word appear on the same clock edge. Strobes on consecutive cycles each load their own word.
- R7: The combinational unary decode that feeds the register always holds as many ones as the segmented value currently on `word_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Load the current word into the output register |
| word_in | input | N | Unsigned sample word |
| unary_q | output | 2^M−1 | Registered thermometer lines, lowest threshold at bit 0 |
| binary_q | output | N−M | Registered low bits of the word |

## Verification
The bench builds the block with N = 10 and M = 6. This gives three nested levels: a fill unit and two decoder stages. Every one of the 1024 input words is then applied, so each unary line is seen at its threshold and at both ends of the range. Among the words are all-zeros, all-ones, and the group-boundary values where the upper pairs hand over. It also covers back-to-back strobes, word changes with the strobe low, and a reset in the middle of the run.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  // Number of unary lines for a segmented field of m bits.
  function automatic int unary_lines(input int m);
    return (1 << m) - 1;
  endfunction

  // Number of bit-pair levels in the hierarchy.
  function automatic int pair_levels(input int m);
    return m / 2;
  endfunction

  // Width of the thermometer vector produced by level j (0-based).
  function automatic int level_width(input int j);
    return (1 << (2 * (j + 1))) - 1;
  endfunction

endpackage

// File: rtl/seg_dec2to4.sv
// Active-low 2-to-4 decoder with active-low enable.
module seg_dec2to4 (
  input  logic       en_n,
  input  logic [1:0] sel,
  output logic [3:0] out_n
);
  always_comb begin
    out_n = 4'b1111;
    if (!en_n) out_n[sel] = 1'b0;
  end
endmodule

// File: rtl/seg_pair_fill.sv
// Lowest level: fills three lines from a 2-bit value, built as a
// zipper over the active-low decoder outputs.
module seg_pair_fill (
  input  logic [1:0] pair,
  output logic [2:0] fill
);
  logic [3:0] hit_n;

  seg_dec2to4 u_dec (
    .en_n (1'b0),
    .sel  (pair),
    .out_n(hit_n)
  );

  logic z2, z1;
  assign z2   = ~hit_n[3];
  assign z1   = z2 | ~hit_n[2];
  assign fill = {z2, z1, hit_n[0] & (z1 | ~hit_n[1])};
endmodule

// File: rtl/seg_level.sv
// One hierarchy level: an upper pair chooses the partial group, groups
// below are full, groups above are empty, boundary lines sit between.
module seg_level #(
  parameter int SUB_W = 3,
  localparam int OUT_W = 4 * SUB_W + 3
) (
  input  logic [1:0]       pair,
  input  logic [SUB_W-1:0] sub,
  output logic [OUT_W-1:0] vec
);
  logic [3:0] grp_n;
  logic [2:0] above;

  seg_dec2to4 u_dec (
    .en_n (1'b0),
    .sel  (pair),
    .out_n(grp_n)
  );

  // above[g] is 1 when the upper pair exceeds g
  assign above[0] = grp_n[0];
  assign above[1] = grp_n[0] & grp_n[1];
  assign above[2] = grp_n[0] & grp_n[1] & grp_n[2];

  for (genvar g = 0; g < 4; g++) begin : g_grp
    localparam int BASE = g * (SUB_W + 1);
    logic [SUB_W-1:0] part;
    // enable-gated pass of the finer pattern (active-low enable)
    assign part = grp_n[g] ? '0 : sub;
    if (g < 3) begin : g_full
      assign vec[BASE +: SUB_W] = above[g] ? '1 : part;
      assign vec[BASE + SUB_W]  = above[g];
    end else begin : g_top
      assign vec[BASE +: SUB_W] = part;
    end
  end
endmodule

// File: rtl/seg_thermo.sv
// Chain of levels turning an M-bit value into 2^M-1 unary lines.
module seg_thermo
  import seg_dac_pkg::*;
#(
  parameter int M = 6,
  localparam int TW  = unary_lines(M),
  localparam int LVL = pair_levels(M)
) (
  input  logic [M-1:0]  seg_val,
  output logic [TW-1:0] therm
);
  for (genvar j = 0; j < LVL; j++) begin : g_lvl
    localparam int W = level_width(j);
    logic [W-1:0] vec;
    if (j == 0) begin : g_base
      seg_pair_fill u_fill (
        .pair(seg_val[1:0]),
        .fill(vec)
      );
    end else begin : g_up
      seg_level #(.SUB_W(level_width(j - 1))) u_lvl (
        .pair(seg_val[2*j +: 2]),
        .sub (g_lvl[j-1].vec),
        .vec (vec)
      );
    end
  end

  assign therm = g_lvl[LVL-1].vec;
endmodule

// File: rtl/seg_out_reg.sv
// Parallel load register with async clear and strobe enable.
module seg_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/seg_dac_coder.sv
module seg_dac_coder
  import seg_dac_pkg::*;
#(
  parameter int N = 16,
  parameter int M = 6,
  localparam int TW = unary_lines(M),
  localparam int BW = N - M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic [N-1:0]  word_in,
  output logic [TW-1:0] unary_q,
  output logic [BW-1:0] binary_q
);
  if (M < 2 || M > 8 || (M % 2) != 0 || N <= M) begin : g_bad_cfg
    $error("seg_dac_coder: M must be even in 2..8 and below N");
  end

  logic [M-1:0]  seg_val;
  logic [TW-1:0] unary_d;

  assign seg_val = word_in[N-1 -: M];

  seg_thermo #(.M(M)) u_thermo (
    .seg_val(seg_val),
    .therm  (unary_d)
  );

  seg_out_reg #(.W(TW + BW)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sample_stb),
    .d    ({unary_d, word_in[BW-1:0]}),
    .q    ({unary_q, binary_q})
  );
endmodule

// File: rtl/seg_dac_coder_chk.sv
module seg_dac_coder_chk #(
  parameter int N = 16,
  parameter int M = 6,
  localparam int TW = (1 << M) - 1,
  localparam int BW = N - M
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic [N-1:0]  word_in,
  input logic [TW-1:0] unary_q,
  input logic [BW-1:0] binary_q,
  input logic [TW-1:0] unary_d
);
  a_r1_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((unary_q + TW'(1)) & unary_q) == '0);

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sample_stb) && $past(rst_n) |->
      $countones(unary_q) == int'($past(word_in[N-1 -: M])));

  a_r3_binary: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sample_stb) && $past(rst_n) |->
      binary_q == $past(word_in[BW-1:0]));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) && $past(rst_n) |->
      $stable(unary_q) && $stable(binary_q));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r5_reset_clear: assert (unary_q == '0 && binary_q == '0);
    end
  end

  a_r7_decode_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unary_d) == int'(word_in[N-1 -: M]));
endmodule

bind seg_dac_coder seg_dac_coder_chk #(.N(N), .M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_stb(sample_stb),
  .word_in   (word_in),
  .unary_q   (unary_q),
  .binary_q  (binary_q),
  .unary_d   (unary_d)
);

// File: tb/test_seg_dac_coder.sv
`timescale 1ns/1ps
module test_seg_dac_coder;
  localparam int N  = 10;
  localparam int M  = 6;
  localparam int TW = (1 << M) - 1;
  localparam int BW = N - M;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_stb = 1'b0;
  logic [N-1:0]  word_in = '0;
  logic [TW-1:0] unary_q;
  logic [BW-1:0] binary_q;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [TW-1:0] un;
    logic [BW-1:0] bi;
    logic [M-1:0]  sv;
  } exp_t;

  exp_t sb_q[$];
  exp_t last_exp;
  logic stb_seen = 1'b0;

  always #5 clk = ~clk;

  seg_dac_coder #(.N(N), .M(M)) i_seg_dac_coder (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .word_in(word_in), .unary_q(unary_q), .binary_q(binary_q)
  );

  function automatic exp_t model(input logic [N-1:0] w);
    exp_t e;
    int v;
    v = int'(w[N-1:BW]);
    e.un = TW'((64'd1 << v) - 64'd1);
    e.bi = w[BW-1:0];
    e.sv = w[N-1:BW];
    return e;
  endfunction

  task automatic check_eq(input string req, input logic [127:0] act,
                          input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one strobed word, optional idle gap
  task automatic send(input logic [N-1:0] w, input bit gap);
    @(negedge clk);
    word_in    = w;
    sample_stb = 1'b1;
    sb_q.push_back(model(w));
    last_exp = model(w);
    if (gap) begin
      @(negedge clk);
      sample_stb = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) stb_seen <= sample_stb && rst_n;

  // monitor: compare one result per registered strobe
  initial begin
    forever begin
      @(negedge clk);
      if (stb_seen && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_eq("R1 unary lines", 128'(unary_q), 128'(e.un));
        check_eq("R2 ones count", 128'($countones(unary_q)), 128'(e.sv));
        check_eq("R3 binary field", 128'(binary_q), 128'(e.bi));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: cleared during reset
    check_eq("R5 reset unary", 128'(unary_q), 128'(0));
    check_eq("R5 reset binary", 128'(binary_q), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R5 after release", 128'({unary_q, binary_q}), 128'(0));

    // R1 R2 R3: corner words (zero, full, group boundaries)
    send('0, 1'b1);
    send('1, 1'b1);
    send(N'(16 << BW), 1'b1);
    send(N'((15 << BW) | 5), 1'b1);
    send(N'(9 << BW), 1'b1);

    // R6: back-to-back strobes, each word loaded on its own edge
    send(N'((3 << BW) | 1), 1'b0);
    send(N'((48 << BW) | 2), 1'b0);
    send(N'((47 << BW) | 14), 1'b0);
    send(N'((63 << BW) | 0), 1'b1);
    drain();

    // R4: word changes with strobe low are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      word_in = N'(i * 97 + 13);
      @(negedge clk);
      check_eq("R4 hold unary", 128'(unary_q), 128'(last_exp.un));
      check_eq("R4 hold binary", 128'(binary_q), 128'(last_exp.bi));
    end

    // exhaustive sweep, R1 R2 R3 with alternating gaps (R6)
    for (int w = 0; w < (1 << N); w++) begin
      send(N'(w), w[0]);
    end
    drain();

    // R5: reset in mid run clears loaded outputs
    send('1, 1'b1);
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R5 mid-run clear", 128'({unary_q, binary_q}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    send(N'((21 << BW) | 7), 1'b1);
    drain();

    summary();
    $finish;
  end
endmodule